// File: doc/BRIEF.md
# Multi-Source Reset Generator Controller

This block merges every reset request of a chip into three domain reset outputs with nested coverage. The widest level, a true power-on, resets every domain. This includes the always-on domain that holds the clock generator, the real-time clock and the system timer. A power-on-initialization level resets the power-management domain and the general core domain. A power-on-reset level resets only the general core domain. That level is raised by the external pin, a core reset request, a debugger, a watchdog expiry, a brown-out-high event or a software command.

The power-on and external pins are asynchronous. They raise their outputs immediately, without waiting for a clock edge. They are released through a two-flop synchronizer. Every output stays asserted for `HOLD_CYC` cycles after its last request. A sticky cause register records each reset cause and each per-supply brown-out event. Only a power-on or an explicit clear command wipes it. The register port also holds enables for the watchdog and brown-out reset paths, and a brown-out-high interrupt with enable, write-one-to-clear and raw and masked views.

The register port is a plain write strobe with an address and data. Read data is registered and appears one cycle after the address.

Top module: `rstgen_ctrl`

## Requirements
- R1: While `rst` is high, all three reset outputs are high, and they stay high for 16 edges after the last edge that sees `rst`. The status register, the configuration (address 1) and the interrupt enable all read 0 afterwards.
- R2: Writing address 0 with bit 0 set (software POR command) raises `rst_core_o` after the second clock edge counted from the write edge. `rst_pmu_o` and `rst_aon_o` stay low.
- R3: Writing address 0 with bit 1 set (software POI command) raises `rst_core_o` and `rst_pmu_o` but not `rst_aon_o`.
- R4: `por_req_i` raises all three outputs without waiting for a clock edge. While it is seen through the synchronizer, the status register (address 2) becomes exactly bit 0 (power-on), and every other cause bit is cleared.
- R5: `ext_req_i` raises `rst_core_o` without waiting for a clock edge. It leaves the other two outputs low and sets status bit 1.
- R6: An output falls exactly 16 edges after the last edge at which its request was seen. For an asynchronous request that edge is the second one after the pin is released.
- R7: `wdt_req_i` resets the core domain and sets status bit 2 only when configuration bit 1 (address 1) is set. Otherwise it has no effect.
- R8: `bod_high_i` resets the core domain and sets status bit 6 only when configuration bit 0 is set. Otherwise it has no effect.
- R9: `dbg_req_i` sets status bit 3. `core_req_i` and the software POR command set bit 4, and the software POI command sets bit 5. All cause bits are sticky across every reset except power-on.
- R10: `bod_supply_i[k]` sets status bit 7+k regardless of any enable, where k is 0 for core, 1 for memory, 2 for burst and 3 for unregulated.
- R11: Writing address 0 with bit 2 set clears the whole status register. A cause seen in the same cycle as the clear remains set.
- R12: Interrupt raw bit (address 4, bit 0) is set while `bod_high_i` is high and cleared by writing 1 there, with the set winning on a tie. Address 3 bit 0 is the enable, address 5 reads raw AND enable, and `irq_o` equals that masked bit.
- R13: `rst_aon_o` high implies `rst_pmu_o` high, which implies `rst_core_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| por_req_i | input | 1 | Asynchronous power-on request |
| ext_req_i | input | 1 | Asynchronous external reset pin |
| wdt_req_i | input | 1 | Watchdog expiry, synchronous level |
| dbg_req_i | input | 1 | Debugger reset request, synchronous level |
| core_req_i | input | 1 | Core reset request, synchronous level |
| bod_high_i | input | 1 | Brown-out-high detect level |
| bod_supply_i | input | 4 | Per-supply brown-out event levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Registered read data for the last address |
| irq_o | output | 1 | Masked brown-out-high interrupt |
| rst_core_o | output | 1 | Core domain reset |
| rst_pmu_o | output | 1 | Power-management domain reset |
| rst_aon_o | output | 1 | Always-on domain reset |

## Verification
The status clear command and a new reset cause can land on the same clock edge. The bench provokes this by holding an enabled watchdog request in the very cycle that writes the clear bit. It judges the outcome by reading the status afterwards: the watchdog bit must be the only bit left. The interrupt has the same contention between its write-one-to-clear and `bod_high_i`, and the bench checks that the raw bit survives.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  // register addresses
  localparam int ADDR_CMD  = 0;
  localparam int ADDR_CFG  = 1;
  localparam int ADDR_STAT = 2;
  localparam int ADDR_IEN  = 3;
  localparam int ADDR_IRAW = 4;
  localparam int ADDR_IMSK = 5;
  // command bits
  localparam int CMD_POR_BIT = 0;
  localparam int CMD_POI_BIT = 1;
  localparam int CMD_CLR_BIT = 2;
  // configuration bits
  localparam int CFG_BOD_BIT = 0;
  localparam int CFG_WDT_BIT = 1;
  // status bits
  localparam int ST_PWR   = 0;
  localparam int ST_EXT   = 1;
  localparam int ST_WDT   = 2;
  localparam int ST_DBG   = 3;
  localparam int ST_SWPOR = 4;
  localparam int ST_SWPOI = 5;
  localparam int ST_BOD   = 6;
  localparam int ST_SUP0  = 7;
  localparam int NSUP     = 4;
  localparam int STAT_W   = ST_SUP0 + NSUP;
  // domains
  localparam int DOM_CORE = 0;
  localparam int DOM_PMU  = 1;
  localparam int DOM_AON  = 2;
  localparam int NDOM     = 3;
endpackage

// File: rtl/rstgen_sync2.sv
module rstgen_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic areq_i,
  input  logic sreq_i,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;
  logic          req;

  // asynchronous set, synchronous release
  always_ff @(posedge clk or posedge areq_i) begin
    if (areq_i)   sync_q <= 2'b11;
    else if (rst) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b0};
  end

  assign req = sync_q[1] | sreq_i;

  always_ff @(posedge clk or posedge areq_i) begin
    if (areq_i || rst || req) begin
      out_q <= 1'b1;
      cnt_q <= CW'(HOLD);
    end else begin
      out_q <= (cnt_q > CW'(1));
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign rst_o = out_q;

  AST_SREQ_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    sreq_i |=> rst_o); // R6
  AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> $past(!req)); // R6
endmodule

// File: rtl/rstgen_regs.sv
module rstgen_regs
  import rstgen_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              por_s_i,
  input  logic              ext_s_i,
  input  logic              wdt_req_i,
  input  logic              dbg_req_i,
  input  logic              core_req_i,
  input  logic              bod_high_i,
  input  logic [NSUP-1:0]   bod_supply_i,
  output logic              cmd_por_o,
  output logic              cmd_poi_o,
  output logic              wdt_en_o,
  output logic              bod_en_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, stat_n, set_vec;
  logic              wdt_en_q, bod_en_q, ien_q, iraw_q, irq_q;
  logic              ien_n, iraw_n;
  logic              cmd_por_q, cmd_poi_q;
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic              wr_cmd, wr_cfg, wr_ien, wr_iraw, do_clear;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata_i[DATA_W-1:3];

  assign wr_cmd  = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CMD));
  assign wr_cfg  = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CFG));
  assign wr_ien  = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_IEN));
  assign wr_iraw = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_IRAW));
  assign do_clear = wr_cmd && reg_wdata_i[CMD_CLR_BIT];

  always_comb begin
    set_vec           = '0;
    set_vec[ST_EXT]   = ext_s_i;
    set_vec[ST_WDT]   = wdt_req_i && wdt_en_q;
    set_vec[ST_DBG]   = dbg_req_i;
    set_vec[ST_SWPOR] = cmd_por_q || core_req_i;
    set_vec[ST_SWPOI] = cmd_poi_q;
    set_vec[ST_BOD]   = bod_high_i && bod_en_q;
    for (int k = 0; k < NSUP; k++) set_vec[ST_SUP0 + k] = bod_supply_i[k];
  end

  always_comb begin
    if (por_s_i) begin
      stat_n         = '0;
      stat_n[ST_PWR] = 1'b1;
    end else begin
      stat_n = (do_clear ? '0 : stat_q) | set_vec;
    end
    iraw_n = (iraw_q && !(wr_iraw && reg_wdata_i[0])) || bod_high_i;
    ien_n  = wr_ien ? reg_wdata_i[0] : ien_q;
  end

  always_comb begin
    rdata_n = '0;
    case (reg_addr_i)
      ADDR_W'(ADDR_CFG): begin
        rdata_n[CFG_BOD_BIT] = bod_en_q;
        rdata_n[CFG_WDT_BIT] = wdt_en_q;
      end
      ADDR_W'(ADDR_STAT): rdata_n[STAT_W-1:0] = stat_q;
      ADDR_W'(ADDR_IEN):  rdata_n[0] = ien_q;
      ADDR_W'(ADDR_IRAW): rdata_n[0] = iraw_q;
      ADDR_W'(ADDR_IMSK): rdata_n[0] = iraw_q && ien_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= '0;
      wdt_en_q  <= 1'b0;
      bod_en_q  <= 1'b0;
      ien_q     <= 1'b0;
      iraw_q    <= 1'b0;
      irq_q     <= 1'b0;
      cmd_por_q <= 1'b0;
      cmd_poi_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      stat_q    <= stat_n;
      if (wr_cfg) begin
        wdt_en_q <= reg_wdata_i[CFG_WDT_BIT];
        bod_en_q <= reg_wdata_i[CFG_BOD_BIT];
      end
      ien_q     <= ien_n;
      iraw_q    <= iraw_n;
      irq_q     <= iraw_n && ien_n;
      cmd_por_q <= wr_cmd && reg_wdata_i[CMD_POR_BIT];
      cmd_poi_q <= wr_cmd && reg_wdata_i[CMD_POI_BIT];
      rdata_q   <= rdata_n;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign cmd_por_o   = cmd_por_q;
  assign cmd_poi_o   = cmd_poi_q;
  assign wdt_en_o    = wdt_en_q;
  assign bod_en_o    = bod_en_q;
  assign irq_o       = irq_q;

  AST_PWR_ONLY: assert property (@(posedge clk) disable iff (rst)
    por_s_i |=> (stat_q == STAT_W'(1) << ST_PWR)); // R4
  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (rst)
    (!por_s_i && !do_clear) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (do_clear && !por_s_i && !ext_s_i && !wdt_req_i && !dbg_req_i && !core_req_i
     && !bod_high_i && (bod_supply_i == '0) && !cmd_por_q && !cmd_poi_q)
    |=> (stat_q == '0)); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (iraw_q && ien_q)); // R12
  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    bod_high_i |=> iraw_q); // R12
endmodule

// File: rtl/rstgen_ctrl.sv
module rstgen_ctrl
  import rstgen_pkg::*;
#(
  parameter int HOLD_CYC = 16,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_req_i,
  input  logic              ext_req_i,
  input  logic              wdt_req_i,
  input  logic              dbg_req_i,
  input  logic              core_req_i,
  input  logic              bod_high_i,
  input  logic [NSUP-1:0]   bod_supply_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              rst_core_o,
  output logic              rst_pmu_o,
  output logic              rst_aon_o
);
  logic [1:0]      pin_s;   // [0] power-on, [1] external
  logic            cmd_por, cmd_poi, wdt_en, bod_en;
  logic [NDOM-1:0] areq, sreq, dom_rst;

  rstgen_sync2 #(.W(2)) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ext_req_i, por_req_i}),
    .q_o (pin_s)
  );

  rstgen_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .por_s_i      (pin_s[0]),
    .ext_s_i      (pin_s[1]),
    .wdt_req_i    (wdt_req_i),
    .dbg_req_i    (dbg_req_i),
    .core_req_i   (core_req_i),
    .bod_high_i   (bod_high_i),
    .bod_supply_i (bod_supply_i),
    .cmd_por_o    (cmd_por),
    .cmd_poi_o    (cmd_poi),
    .wdt_en_o     (wdt_en),
    .bod_en_o     (bod_en),
    .irq_o        (irq_o)
  );

  // domain coverage per reset level
  always_comb begin
    areq           = '0;
    sreq           = '0;
    areq[DOM_CORE] = por_req_i || ext_req_i;
    areq[DOM_PMU]  = por_req_i;
    areq[DOM_AON]  = por_req_i;
    sreq[DOM_CORE] = cmd_por || cmd_poi || core_req_i || dbg_req_i
                     || (wdt_req_i && wdt_en) || (bod_high_i && bod_en);
    sreq[DOM_PMU]  = cmd_poi;
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    rstgen_stretch #(.HOLD(HOLD_CYC)) u_stretch (
      .clk    (clk),
      .rst    (rst),
      .areq_i (areq[d]),
      .sreq_i (sreq[d]),
      .rst_o  (dom_rst[d])
    );
  end

  assign rst_core_o = dom_rst[DOM_CORE];
  assign rst_pmu_o  = dom_rst[DOM_PMU];
  assign rst_aon_o  = dom_rst[DOM_AON];

  AST_PMU_IN_CORE: assert property (@(posedge clk) disable iff (rst)
    rst_pmu_o |-> rst_core_o); // R13
  AST_AON_IN_PMU: assert property (@(posedge clk) disable iff (rst)
    rst_aon_o |-> rst_pmu_o); // R13
  AST_WDT_GATED: assert property (@(posedge clk) disable iff (rst)
    (!rst_core_o && !por_req_i && !ext_req_i && !pin_s[1] && wdt_req_i && !wdt_en
     && !cmd_por && !cmd_poi && !core_req_i && !dbg_req_i && !bod_high_i)
    |=> !rst_core_o); // R7
endmodule

// File: tb/rstgen_ctrl_tb.sv
module rstgen_ctrl_tb_top;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_req = 0, ext_req = 0, wdt_req = 0, dbg_req = 0, core_req = 0, bod_high = 0;
  logic [3:0] bod_supply = '0;
  logic reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq, rcore, rpmu, raon;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] rv;

  always #2 clk = ~clk;

  rstgen_ctrl dut_i (
    .clk(clk), .rst(rst), .por_req_i(por_req), .ext_req_i(ext_req),
    .wdt_req_i(wdt_req), .dbg_req_i(dbg_req), .core_req_i(core_req),
    .bod_high_i(bod_high), .bod_supply_i(bod_supply), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .rst_core_o(rcore), .rst_pmu_o(rpmu), .rst_aon_o(raon)
  );

  // src: 0 wdt, 1 dbg, 2 core_req, 3 bod_high, 4 cmd POR, 5 cmd POI
  typedef struct packed {
    logic [2:0]  src;
    logic [1:0]  cfg;
    logic        core;
    logic        pmu;
    logic [10:0] stat;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{3'd0, 2'b10, 1'b1, 1'b0, 11'h004},
    '{3'd0, 2'b00, 1'b0, 1'b0, 11'h000},
    '{3'd1, 2'b00, 1'b1, 1'b0, 11'h008},
    '{3'd2, 2'b00, 1'b1, 1'b0, 11'h010},
    '{3'd3, 2'b01, 1'b1, 1'b0, 11'h040},
    '{3'd3, 2'b00, 1'b0, 1'b0, 11'h000},
    '{3'd4, 2'b00, 1'b1, 1'b0, 11'h010},
    '{3'd5, 2'b00, 1'b1, 1'b1, 11'h020},
    '{3'd0, 2'b01, 1'b0, 1'b0, 11'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    reg_addr = AW'(a);
    @(posedge clk);
    #1 v = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_rst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    wait_cyc(20);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state and release timing
    repeat (3) @(posedge clk);
    #1;
    chk("R1 core in reset", {29'd0, rcore, rpmu, raon}, 32'h7);
    @(negedge clk); rst = 1'b0;
    repeat (15) @(posedge clk);
    #1 chk("R1 held 15 edges", {29'd0, rcore, rpmu, raon}, 32'h7);
    @(posedge clk);
    #1 chk("R1 released at 16", {29'd0, rcore, rpmu, raon}, 32'h0);
    rd(2, rv); chk("R1 status zero", 32'(rv), 32'h0);
    rd(1, rv); chk("R1 cfg zero", 32'(rv), 32'h0);
    rd(3, rv); chk("R1 irq enable zero", 32'(rv), 32'h0);

    // table walk: R2 R3 R7 R8 R9
    for (int i = 0; i < 9; i++) begin
      do_rst();
      wr(1, DW'(VEC[i].cfg));
      if (VEC[i].src == 3'd4) wr(0, DW'(1));
      else if (VEC[i].src == 3'd5) wr(0, DW'(2));
      else begin
        @(negedge clk);
        case (VEC[i].src)
          3'd0: wdt_req = 1'b1;
          3'd1: dbg_req = 1'b1;
          3'd2: core_req = 1'b1;
          default: bod_high = 1'b1;
        endcase
        @(negedge clk);
        wdt_req = 0; dbg_req = 0; core_req = 0; bod_high = 0;
      end
      @(posedge clk);
      #1;
      chk($sformatf("R2/R3/R7/R8 vec%0d core", i), 32'(rcore), 32'(VEC[i].core));
      chk($sformatf("R3 vec%0d pmu", i), 32'(rpmu), 32'(VEC[i].pmu));
      chk($sformatf("R2 vec%0d aon", i), 32'(raon), 32'h0);
      wait_cyc(25);
      rd(2, rv);
      chk($sformatf("R9 vec%0d status", i), 32'(rv), 32'(VEC[i].stat));
    end

    // R6: stretch after a one-cycle synchronous request
    do_rst();
    wr(1, DW'(2));
    @(negedge clk); wdt_req = 1'b1;
    @(posedge clk);
    @(negedge clk); wdt_req = 1'b0;
    repeat (15) @(posedge clk);
    #1 chk("R6 sync held 16", 32'(rcore), 32'h1);
    @(posedge clk);
    #1 chk("R6 sync released", 32'(rcore), 32'h0);

    // R4: power-on asserts all at once and leaves only the power bit
    @(negedge clk); por_req = 1'b1;
    #1 chk("R4 immediate assert", {29'd0, rcore, rpmu, raon}, 32'h7);
    repeat (4) @(negedge clk);
    por_req = 1'b0;
    wait_cyc(25);
    rd(2, rv); chk("R4 status power only", 32'(rv), 32'h001);

    // R5 R6: external pin, async assert, sync release
    @(negedge clk); ext_req = 1'b1;
    #1 chk("R5 core immediate", 32'(rcore), 32'h1);
    chk("R5 pmu/aon untouched", {30'd0, rpmu, raon}, 32'h0);
    repeat (3) @(negedge clk);
    ext_req = 1'b0;
    repeat (17) @(posedge clk);
    #1 chk("R6 async held", 32'(rcore), 32'h1);
    @(posedge clk);
    #1 chk("R6 async released", 32'(rcore), 32'h0);
    rd(2, rv); chk("R5/R9 ext sticky with power", 32'(rv), 32'h003);

    // R10: supply brown-out bits, core=7 mem=8 burst=9 unreg=10
    @(negedge clk); bod_supply = 4'b1010;
    @(negedge clk); bod_supply = 4'b0000;
    rd(2, rv); chk("R10 supply bits", 32'(rv), 32'h503);
    chk("R10 no reset from supply", 32'(rcore), 32'h0);

    // R11: clear with a watchdog cause in the same cycle
    wr(1, DW'(2));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(0); reg_wdata = DW'(4); wdt_req = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; wdt_req = 1'b0;
    rd(2, rv); chk("R11 same-cycle cause kept", 32'(rv), 32'h004);
    wr(0, DW'(4));
    rd(2, rv); chk("R11 clear all", 32'(rv), 32'h000);

    // R12: interrupt
    do_rst();
    @(negedge clk); bod_high = 1'b1;
    @(negedge clk); bod_high = 1'b0;
    rd(4, rv); chk("R12 raw set", 32'(rv), 32'h1);
    rd(5, rv); chk("R12 masked off", 32'(rv), 32'h0);
    chk("R12 irq low when disabled", 32'(irq), 32'h0);
    chk("R8 bod disabled no reset", 32'(rcore), 32'h0);
    wr(3, DW'(1));
    #1 chk("R12 irq high when enabled", 32'(irq), 32'h1);
    rd(5, rv); chk("R12 masked on", 32'(rv), 32'h1);
    wr(4, DW'(1));
    rd(4, rv); chk("R12 w1c clears raw", 32'(rv), 32'h0);
    chk("R12 irq dropped", 32'(irq), 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(4); reg_wdata = DW'(1); bod_high = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; bod_high = 1'b0;
    rd(4, rv); chk("R12 set wins over clear", 32'(rv), 32'h1);

    // R13: nesting seen at the ports during a POI
    wr(0, DW'(2));
    @(posedge clk);
    #1 chk("R13 pmu implies core", {30'd0, rcore, rpmu}, 32'h3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule